// File: doc/BRIEF.md
# TLB Autorefill Page-Table Walker

This block runs when a translation lookaside buffer lookup misses. It accepts the faulting virtual address and builds the address of the page-table entry (PTE) from the page-table base value and that address. It sends the PTE address through the TLB's own lookup port as a privileged load that may not trigger another refill, then reads the 32-bit PTE over a simple memory read port. Finally it either writes the PTE into one of four autorefill ways, picked round-robin, or hands it back as a temporary entry for the current access only.

On completion the block pulses `done_o` for one cycle. On success it reports the entry fields: ring, attribute, physical page, tag, way, and a temporary flag. On failure it returns the miss cause that came with the request. Only one walk runs at a time.

Top module: `ptw_autorefill`

## Requirements
- R1: The PTE address sent for translation is `(ptbase_i | (req_vaddr_i >> 10))` with bits [1:0] forced to zero, using the values present when the request is accepted.
- R2: After a request is accepted, `xl_req_o` is raised and held, with `xl_vaddr_o` stable, until `xl_rsp_valid_i`. The memory read then goes to the returned `xl_paddr_i`.
- R3: If the PTE-address translation fails (`xl_ok_i`=0), the walk ends one cycle later with `done_o`=1 and `done_ok_o`=0. `done_cause_o` equals the request's cause, and no TLB write is made.
- R4: If the memory response arrives with `mem_rsp_err_i`=1, the walk fails in the same way as in R3, with the original cause and no write.
- R5: `mem_req_valid_o` stays high, with `mem_addr_o` stable, until a cycle in which `mem_req_ready_i` is high.
- R6: When `req_update_i` was 1, a successful walk raises `tlb_we_o` for exactly one cycle. That cycle carries the way, the index `vaddr[13:12]`, the tag `vaddr[31:12]` and the full PTE. The way is a 2-bit counter, reset to 0, incremented before use, so successive writes go to ways 1, 2, 3, 0, 1, and so on.
- R7: When `req_update_i` was 0, a successful walk writes nothing and leaves the way counter unchanged. Its completion reports `done_temp_o`=1 and way 0. Failed walks also leave the counter unchanged.
- R8: A successful completion reports `done_ok_o`=1, ring = PTE[5:4], attribute = PTE[3:0], physical page = PTE[31:12], and tag = `vaddr[31:12]`.
- R9: `excvaddr_o` takes the faulting virtual address only when a refill is written to the TLB. Otherwise it keeps its value.
- R10: `req_ready_o` is high only while idle. A request presented during a walk is ignored and does not change the walk's addresses, cause or result.
- R11: After reset, the block is idle and ready, every request, write and done output is low, and `excvaddr_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Miss request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_vaddr_i | input | VA_W | Faulting virtual address |
| req_update_i | input | 1 | 1: write refill into TLB; 0: temporary entry only |
| req_cause_i | input | CAUSE_W | Miss cause to return on failure |
| ptbase_i | input | VA_W | Page-table base value |
| xl_req_o | output | 1 | PTE-address translation request |
| xl_vaddr_o | output | VA_W | PTE virtual address |
| xl_rsp_valid_i | input | 1 | Translation response |
| xl_ok_i | input | 1 | Translation hit with load permission |
| xl_paddr_i | input | VA_W | Translated PTE physical address |
| mem_req_valid_o | output | 1 | Memory read request |
| mem_req_ready_i | input | 1 | Memory accepts request |
| mem_addr_o | output | VA_W | Memory read address |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_err_i | input | 1 | Read error |
| mem_rsp_data_i | input | VA_W | PTE read data |
| tlb_we_o | output | 1 | TLB refill write strobe |
| tlb_way_o | output | WAY_W | Refill way |
| tlb_idx_o | output | IDX_W | Entry index in way |
| tlb_vpn_o | output | VA_W-12 | Entry tag |
| tlb_pte_o | output | VA_W | PTE written |
| excvaddr_o | output | VA_W | Exception virtual address |
| done_o | output | 1 | Walk complete |
| done_ok_o | output | 1 | Walk succeeded |
| done_cause_o | output | CAUSE_W | Original miss cause |
| done_temp_o | output | 1 | Result is a temporary entry |
| done_way_o | output | WAY_W | Way used (0 for temporary) |
| done_ring_o | output | 2 | Ring from PTE |
| done_attr_o | output | 4 | Attribute from PTE |
| done_ppn_o | output | VA_W-12 | Physical page from PTE |
| done_vpn_o | output | VA_W-12 | Tag of faulting address |

## Verification
The assertions assume that the translation and memory responders answer only the request that is currently open. That means `xl_rsp_valid_i` appears only while `xl_req_o` is high, and `mem_rsp_valid_i` appears only after the read has been accepted. They also assume `ptbase_i` is steady at the moment of acceptance. The bench drives each responder strictly from the walker's visible state: it answers translation while `xl_req_o` is seen, raises ready after a chosen delay while `mem_req_valid_o` is seen, and returns data only once the request has dropped. It repeats a busy-time request on purpose to show that the request inputs are the only ones allowed to misbehave.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int ATTR_W     = 4;
  localparam int RING_W     = 2;
  localparam int RING_LSB   = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XLATE,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_INSTALL,
    ST_DONE,
    ST_FAIL
  } walk_st_e;
endpackage

// File: rtl/ptw_pte_addr.sv
module ptw_pte_addr #(
  parameter int VA_W      = 32,
  parameter int PTE_SHIFT = 10
) (
  input  logic [VA_W-1:0] base_i,
  input  logic [VA_W-1:0] vaddr_i,
  output logic [VA_W-1:0] pte_va_o
);
  localparam logic [VA_W-1:0] WORD_MASK = ~(VA_W'(3));

  assign pte_va_o = (base_i | (vaddr_i >> PTE_SHIFT)) & WORD_MASK;
endmodule

// File: rtl/ptw_way_ctr.sv
module ptw_way_ctr #(
  parameter int WAY_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [WAY_W-1:0] nxt_o
);
  logic [WAY_W-1:0] cnt_q;

  // pre-increment: the way used is the counter after the step
  assign nxt_o = cnt_q + WAY_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (adv_i) cnt_q <= nxt_o;
  end

  a_r7_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(nxt_o));
endmodule

// File: rtl/ptw_entry_fmt.sv
module ptw_entry_fmt
  import ptw_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int IDX_W = 2
) (
  input  logic [VA_W-1:0]            vaddr_i,
  input  logic [VA_W-1:0]            pte_i,
  output logic [VA_W-PAGE_SHIFT-1:0] vpn_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [VA_W-PAGE_SHIFT-1:0] ppn_o,
  output logic [ATTR_W-1:0]          attr_o,
  output logic [RING_W-1:0]          ring_o
);
  logic unused_bits;

  assign vpn_o  = vaddr_i[VA_W-1:PAGE_SHIFT];
  assign idx_o  = vaddr_i[PAGE_SHIFT +: IDX_W];
  assign ppn_o  = pte_i[VA_W-1:PAGE_SHIFT];
  assign attr_o = pte_i[ATTR_W-1:0];
  assign ring_o = pte_i[RING_LSB +: RING_W];
  assign unused_bits = ^{vaddr_i[PAGE_SHIFT-1:0], pte_i[PAGE_SHIFT-1:RING_LSB+RING_W]};
endmodule

// File: rtl/ptw_autorefill.sv
module ptw_autorefill
  import ptw_pkg::*;
#(
  parameter int VA_W      = 32,
  parameter int IDX_W     = 2,
  parameter int WAY_W     = 2,
  parameter int CAUSE_W   = 6,
  parameter int PTE_SHIFT = 10
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        req_valid_i,
  output logic                        req_ready_o,
  input  logic [VA_W-1:0]             req_vaddr_i,
  input  logic                        req_update_i,
  input  logic [CAUSE_W-1:0]          req_cause_i,
  input  logic [VA_W-1:0]             ptbase_i,
  output logic                        xl_req_o,
  output logic [VA_W-1:0]             xl_vaddr_o,
  input  logic                        xl_rsp_valid_i,
  input  logic                        xl_ok_i,
  input  logic [VA_W-1:0]             xl_paddr_i,
  output logic                        mem_req_valid_o,
  input  logic                        mem_req_ready_i,
  output logic [VA_W-1:0]             mem_addr_o,
  input  logic                        mem_rsp_valid_i,
  input  logic                        mem_rsp_err_i,
  input  logic [VA_W-1:0]             mem_rsp_data_i,
  output logic                        tlb_we_o,
  output logic [WAY_W-1:0]            tlb_way_o,
  output logic [IDX_W-1:0]            tlb_idx_o,
  output logic [VA_W-PAGE_SHIFT-1:0]  tlb_vpn_o,
  output logic [VA_W-1:0]             tlb_pte_o,
  output logic [VA_W-1:0]             excvaddr_o,
  output logic                        done_o,
  output logic                        done_ok_o,
  output logic [CAUSE_W-1:0]          done_cause_o,
  output logic                        done_temp_o,
  output logic [WAY_W-1:0]            done_way_o,
  output logic [RING_W-1:0]           done_ring_o,
  output logic [ATTR_W-1:0]           done_attr_o,
  output logic [VA_W-PAGE_SHIFT-1:0]  done_ppn_o,
  output logic [VA_W-PAGE_SHIFT-1:0]  done_vpn_o
);
  localparam int VPN_W = VA_W - PAGE_SHIFT;

  walk_st_e           st_q;
  logic [VA_W-1:0]    vaddr_q, pva_q, pa_q, pte_q, exc_q;
  logic [CAUSE_W-1:0] cause_q;
  logic               upd_q;
  logic [WAY_W-1:0]   way_q, way_nxt;
  logic [VA_W-1:0]    pva_d;
  logic [VPN_W-1:0]   vpn_w, ppn_w;
  logic [IDX_W-1:0]   idx_w;
  logic [ATTR_W-1:0]  attr_w;
  logic [RING_W-1:0]  ring_w;
  logic               install_we;

  ptw_pte_addr #(.VA_W(VA_W), .PTE_SHIFT(PTE_SHIFT)) u_addr (
    .base_i   (ptbase_i),
    .vaddr_i  (req_vaddr_i),
    .pte_va_o (pva_d)
  );

  ptw_way_ctr #(.WAY_W(WAY_W)) u_way (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (install_we),
    .nxt_o  (way_nxt)
  );

  ptw_entry_fmt #(.VA_W(VA_W), .IDX_W(IDX_W)) u_fmt (
    .vaddr_i (vaddr_q),
    .pte_i   (pte_q),
    .vpn_o   (vpn_w),
    .idx_o   (idx_w),
    .ppn_o   (ppn_w),
    .attr_o  (attr_w),
    .ring_o  (ring_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      pva_q   <= '0;
      pa_q    <= '0;
      pte_q   <= '0;
      exc_q   <= '0;
      cause_q <= '0;
      upd_q   <= 1'b0;
      way_q   <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          pva_q   <= pva_d;
          cause_q <= req_cause_i;
          upd_q   <= req_update_i;
          st_q    <= ST_XLATE;
        end
        ST_XLATE: if (xl_rsp_valid_i) begin
          if (xl_ok_i) begin
            pa_q <= xl_paddr_i;
            st_q <= ST_RD_REQ;
          end else begin
            st_q <= ST_FAIL;
          end
        end
        ST_RD_REQ: if (mem_req_ready_i) st_q <= ST_RD_WAIT;
        ST_RD_WAIT: if (mem_rsp_valid_i) begin
          if (mem_rsp_err_i) begin
            st_q <= ST_FAIL;
          end else begin
            pte_q <= mem_rsp_data_i;
            st_q  <= ST_INSTALL;
          end
        end
        ST_INSTALL: begin
          way_q <= upd_q ? way_nxt : '0;
          if (upd_q) exc_q <= vaddr_q;
          st_q <= ST_DONE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign install_we      = (st_q == ST_INSTALL) && upd_q;
  assign req_ready_o     = (st_q == ST_IDLE);
  assign xl_req_o        = (st_q == ST_XLATE);
  assign xl_vaddr_o      = pva_q;
  assign mem_req_valid_o = (st_q == ST_RD_REQ);
  assign mem_addr_o      = pa_q;
  assign tlb_we_o        = install_we;
  assign tlb_way_o       = way_nxt;
  assign tlb_idx_o       = idx_w;
  assign tlb_vpn_o       = vpn_w;
  assign tlb_pte_o       = pte_q;
  assign excvaddr_o      = exc_q;
  assign done_o          = (st_q == ST_DONE) || (st_q == ST_FAIL);
  assign done_ok_o       = (st_q == ST_DONE);
  assign done_cause_o    = cause_q;
  assign done_temp_o     = (st_q == ST_DONE) && !upd_q;
  assign done_way_o      = way_q;
  assign done_ring_o     = ring_w;
  assign done_attr_o     = attr_w;
  assign done_ppn_o      = ppn_w;
  assign done_vpn_o      = vpn_w;

  a_r2_xl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_o && !xl_rsp_valid_i |=> xl_req_o && $stable(xl_vaddr_o));
  a_r3_xl_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xl_req_o && xl_rsp_valid_i && !xl_ok_i |=> done_o && !done_ok_o && !tlb_we_o);
  a_r4_mem_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RD_WAIT) && mem_rsp_valid_i && mem_rsp_err_i |=> done_o && !done_ok_o);
  a_r5_mem_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_addr_o));
  a_r6_way_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |=> done_o && done_ok_o && (done_way_o == $past(tlb_way_o)));
  a_r6_single_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_we_o |=> !tlb_we_o);
  a_r9_exc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tlb_we_o |=> $stable(excvaddr_o));
  a_r10_accept_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> xl_req_o && !req_ready_o);
  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xl_req_o || mem_req_valid_o || tlb_we_o || done_o) |-> !req_ready_o);
endmodule

// File: tb/sim_ptw_autorefill.sv
`timescale 1ns/1ps
module sim_ptw_autorefill;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic        req_update_i = 1'b0;
  logic [5:0]  req_cause_i = '0;
  logic [31:0] ptbase_i = '0;
  logic        xl_req_o;
  logic [31:0] xl_vaddr_o;
  logic        xl_rsp_valid_i = 1'b0;
  logic        xl_ok_i = 1'b0;
  logic [31:0] xl_paddr_i = '0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [31:0] mem_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_err_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic        tlb_we_o;
  logic [1:0]  tlb_way_o;
  logic [1:0]  tlb_idx_o;
  logic [19:0] tlb_vpn_o;
  logic [31:0] tlb_pte_o;
  logic [31:0] excvaddr_o;
  logic        done_o, done_ok_o, done_temp_o;
  logic [5:0]  done_cause_o;
  logic [1:0]  done_way_o, done_ring_o;
  logic [3:0]  done_attr_o;
  logic [19:0] done_ppn_o, done_vpn_o;

  int checks = 0;
  int errors = 0;
  int wr_seen = 0;
  int exp_ctr = 0;
  logic [31:0] last_exc = '0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  ptw_autorefill u0 (.*);

  always @(negedge clk_i) if (tlb_we_o) wr_seen++;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic [31:0] base, input logic upd,
                      input logic [5:0] cause, input logic xok, input logic [31:0] xpa,
                      input logic merr, input logic [31:0] pte, input int dly, input logic spam);
    int wr0;
    logic [31:0] exp_pva;
    logic [1:0] exp_way;
    wr0 = wr_seen;
    exp_pva = (base | (va >> 10)) & 32'hFFFF_FFFC;
    @(negedge clk_i);
    req_valid_i = 1; req_vaddr_i = va; ptbase_i = base; req_update_i = upd; req_cause_i = cause;
    check(req_ready_o, "R10 ready when idle", {31'b0, req_ready_o}, 1);
    @(negedge clk_i);
    if (spam) begin
      req_vaddr_i = ~va; req_update_i = ~upd; req_cause_i = ~cause;
    end else req_valid_i = 0;
    check(xl_req_o && !req_ready_o, "R2 xlate request", {31'b0, xl_req_o}, 1);
    check(xl_vaddr_o == exp_pva, "R1 pte address", xl_vaddr_o, exp_pva);
    xl_rsp_valid_i = 1; xl_ok_i = xok; xl_paddr_i = xpa;
    @(negedge clk_i);
    xl_rsp_valid_i = 0;
    if (!xok) begin
      check(done_o && !done_ok_o, "R3 fail done", {30'b0, done_o, done_ok_o}, 32'h2);
      check(done_cause_o == cause, "R3 cause", {26'b0, done_cause_o}, {26'b0, cause});
      req_valid_i = 0;
      @(negedge clk_i);
      check(wr_seen == wr0, "R3 no write", wr_seen, wr0);
      check(excvaddr_o == last_exc, "R9 exc kept", excvaddr_o, last_exc);
      return;
    end
    for (int d = 0; d < dly; d++) begin
      check(mem_req_valid_o && mem_addr_o == xpa, "R5 hold request", mem_addr_o, xpa);
      @(negedge clk_i);
    end
    check(mem_req_valid_o && mem_addr_o == xpa, "R2 mem address", mem_addr_o, xpa);
    mem_req_ready_i = 1;
    @(negedge clk_i);
    mem_req_ready_i = 0;
    check(!mem_req_valid_o, "R5 request dropped", {31'b0, mem_req_valid_o}, 0);
    mem_rsp_valid_i = 1; mem_rsp_err_i = merr; mem_rsp_data_i = pte;
    @(negedge clk_i);
    mem_rsp_valid_i = 0; mem_rsp_err_i = 0;
    if (merr) begin
      check(done_o && !done_ok_o, "R4 fail done", {30'b0, done_o, done_ok_o}, 32'h2);
      check(done_cause_o == cause, "R4 cause", {26'b0, done_cause_o}, {26'b0, cause});
      req_valid_i = 0;
      @(negedge clk_i);
      check(wr_seen == wr0, "R4 no write", wr_seen, wr0);
      return;
    end
    if (upd) exp_ctr = (exp_ctr + 1) % 4;
    exp_way = upd ? 2'(exp_ctr) : 2'd0;
    check(tlb_we_o == upd, upd ? "R6 write strobe" : "R7 no write", {31'b0, tlb_we_o}, {31'b0, upd});
    if (upd) begin
      check(tlb_way_o == exp_way, "R6 way", {30'b0, tlb_way_o}, {30'b0, exp_way});
      check(tlb_idx_o == va[13:12], "R6 index", {30'b0, tlb_idx_o}, {30'b0, va[13:12]});
      check(tlb_vpn_o == va[31:12], "R6 tag", {12'b0, tlb_vpn_o}, {12'b0, va[31:12]});
      check(tlb_pte_o == pte, "R6 pte", tlb_pte_o, pte);
    end
    @(negedge clk_i);
    check(done_o && done_ok_o, "R8 ok", {30'b0, done_o, done_ok_o}, 32'h3);
    check(done_ring_o == pte[5:4], "R8 ring", {30'b0, done_ring_o}, {30'b0, pte[5:4]});
    check(done_attr_o == pte[3:0], "R8 attr", {28'b0, done_attr_o}, {28'b0, pte[3:0]});
    check(done_ppn_o == pte[31:12], "R8 ppn", {12'b0, done_ppn_o}, {12'b0, pte[31:12]});
    check(done_vpn_o == va[31:12], "R8 tag", {12'b0, done_vpn_o}, {12'b0, va[31:12]});
    check(done_temp_o == !upd, "R7 temp flag", {31'b0, done_temp_o}, {31'b0, !upd});
    check(done_way_o == exp_way, "R7 done way", {30'b0, done_way_o}, {30'b0, exp_way});
    req_valid_i = 0;
    if (upd) last_exc = va;
    @(negedge clk_i);
    check(excvaddr_o == last_exc, "R9 exception address", excvaddr_o, last_exc);
    check(wr_seen - wr0 == int'(upd), "R6 one write", wr_seen - wr0, {31'b0, upd});
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check(req_ready_o && !done_o && !tlb_we_o && !xl_req_o && !mem_req_valid_o,
          "R11 reset outputs", {27'b0, req_ready_o, done_o, tlb_we_o, xl_req_o, mem_req_valid_o}, 32'h10);
    check(excvaddr_o == 0, "R11 reset exc", excvaddr_o, 0);
    rst_ni = 1;
    for (int i = 0; i < 40; i++) begin
      logic [31:0] va, base, xpa, pte;
      va   = 32'h9E37_79B9 * (i + 1);
      base = (32'h00C0_0000 * i) & 32'hFFC0_0000;
      xpa  = 32'h4000_0000 ^ (32'h0001_0104 * i);
      pte  = (va * 3) ^ (32'h5A5A_0F00 + i);
      walk(va, base, (i % 3) != 2, 6'(i + 16), (i % 7) != 5, xpa, (i % 7) == 6, pte, i % 4, (i % 5) == 4);
    end
    finish_run();
  end
endmodule